// File: doc/BRIEF.md
# Frequency-Ordered Split Code Table

This block decodes one prefix code (Huffman style) at a time from a window of stream bits that is already aligned. Its codebook is divided into three sub-tables. The smallest sub-table holds the most frequent codes and is tried first. A mid-size sub-table is tried next, and the largest one last. The first sub-table whose entries match the window ends the search. The block then reports the symbol, the code length (so that an upstream aligner can drop that many bits) and the index of the sub-table that matched. The aligned bits themselves are the match key. There is no stage that converts codes to addresses.

Each sub-table has its own key register. That register loads only when the search reaches its sub-table, so sub-tables that a search does not reach see no switching inputs. A final multiplexer, steered by the index of the matching sub-table, drives the registered result. If a window matches no sub-table, the block reports an error with length 0 and becomes ready for the next code.

Top module: `vlc_part_table`

## Requirements
- R1: While reset is asserted, outValid is 0 and inReady is 1.
- R2: Sub-table 0 decodes three codes, matched in the top bits of inCode: `11` gives symbol 0 with length 2, `101` gives symbol 1 with length 3, and `100` gives symbol 2 with length 3. outBlk is 0 for these codes.
- R3: Sub-table 1 decodes the 6-bit codes whose value v lies in 20..31. Each gives symbol v-17 with length 6 and outBlk 1.
- R4: Sub-table 2 decodes two groups of codes, each with outBlk 2. The first group is `00` followed by an 8-bit value a < 100, which gives symbol 15+a with length 10. The second group is `0100` followed by a 12-bit value b < 16, which gives symbol 115+b with length 16.
- R5: A window that matches no sub-table produces a result with outErr=1, outLen=0, outSym=0 and outBlk=3. The block is then idle and ready.
- R6: A code that is accepted on one rising edge and matches sub-table k appears on the outputs after k+1 further rising edges. A window that matches nothing appears after 3 further rising edges. Bits of inCode below the code length have no effect on the result.
- R7: inReady is 1 when the block is idle and in the last cycle of a search. It is 0 in a cycle where a search is still going to continue. As a result, back-to-back sub-table 0 codes are accepted and decoded one per cycle.
- R8: In any cycle, at most one sub-table key register loads. A sub-table's key register keeps its value in every cycle in which its search step is not taken.
- R9: outValid is high for exactly one cycle for each accepted code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | inCode holds an aligned window |
| inReady | output | 1 | The window is taken on this edge if inValid is 1 |
| inCode | input | 16 | Left-aligned window; the code starts at bit 15 |
| outValid | output | 1 | One-cycle strobe for a result |
| outSym | output | 8 | Decoded symbol |
| outLen | output | 5 | Code length in bits (0 on error) |
| outBlk | output | 2 | Index of the matching sub-table; 3 on error |
| outErr | output | 1 | The window matched no sub-table |

## Verification
On every cycle, the assertions check three things. First, the load discipline of the key registers: only one loads at a time, and each holds when it is not loaded. Second, that inReady drops while a search continues. Third, that each result comes exactly two edges after its own sub-table's key register loaded, with the error form tied to the last sub-table. Only the bench scenarios can show that the decoded symbols and lengths follow the codebook, that low tail bits are ignored, that a stream of frequent codes runs at one result per cycle, and that results and accepted codes match one for one.

// File: rtl/vlc_pkg.sv
package vlc_pkg;
  localparam int CODE_W = 16;
  localparam int SYM_W  = 8;
  localparam int LEN_W  = 5;
  localparam int NBLK   = 3;
  localparam int BLK_W  = $clog2(NBLK + 1);
  localparam int NPAD   = 2 ** BLK_W;
  localparam logic [BLK_W-1:0] NO_BLK = '1;

  typedef struct packed {
    logic             hit;
    logic [SYM_W-1:0] sym;
    logic [LEN_W-1:0] len;
  } look_t;

  // strobes from control to datapath
  typedef struct packed {
    logic [NBLK-1:0]  load;
    logic [BLK_W-1:0] sel;
    logic             takeHit;
    logic             takeMiss;
  } strobe_t;

  // smallest, most frequent codes
  function automatic look_t lookBlk0(input logic [CODE_W-1:0] key);
    look_t r;
    r = '0;
    if (key[CODE_W-1 -: 2] == 2'b11) begin
      r.hit = 1'b1; r.sym = SYM_W'(0); r.len = LEN_W'(2);
    end else if (key[CODE_W-1 -: 3] == 3'b101) begin
      r.hit = 1'b1; r.sym = SYM_W'(1); r.len = LEN_W'(3);
    end else if (key[CODE_W-1 -: 3] == 3'b100) begin
      r.hit = 1'b1; r.sym = SYM_W'(2); r.len = LEN_W'(3);
    end
    return r;
  endfunction

  // twelve 6-bit codes
  function automatic look_t lookBlk1(input logic [CODE_W-1:0] key);
    look_t r;
    logic [5:0] v;
    r = '0;
    v = key[CODE_W-1 -: 6];
    if (v >= 6'd20) begin
      r.hit = 1'b1; r.sym = SYM_W'(v) - SYM_W'(17); r.len = LEN_W'(6);
    end
    return r;
  endfunction

  // rare codes: 10-bit and 16-bit groups
  function automatic look_t lookBlk2(input logic [CODE_W-1:0] key);
    look_t r;
    logic [7:0] a;
    r = '0;
    a = key[CODE_W-3 -: 8];
    if (key[CODE_W-1 -: 2] == 2'b00 && a < 8'd100) begin
      r.hit = 1'b1; r.sym = SYM_W'(15) + SYM_W'(a); r.len = LEN_W'(10);
    end else if (key[CODE_W-1 -: 4] == 4'b0100 && key[CODE_W-5 -: 8] == 8'd0) begin
      r.hit = 1'b1; r.sym = SYM_W'(115) + SYM_W'(key[3:0]); r.len = LEN_W'(16);
    end
    return r;
  endfunction
endpackage

// File: rtl/vlc_subtable.sv
module vlc_subtable
  import vlc_pkg::*;
#(
  parameter int BLK = 0
) (
  input  logic [CODE_W-1:0] key,
  output look_t             res
);
  generate
    if (BLK == 0) begin : g_b0
      assign res = lookBlk0(key);
    end else if (BLK == 1) begin : g_b1
      assign res = lookBlk1(key);
    end else begin : g_b2
      assign res = lookBlk2(key);
    end
  endgenerate
endmodule

// File: rtl/vlc_ctrl.sv
module vlc_ctrl
  import vlc_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic            inValid,
  input  logic [NBLK-1:0] hitVec,
  output logic            inReady,
  output strobe_t         strb
);
  logic [BLK_W-1:0] stepQ, stepD;
  logic [NPAD-1:0]  hitPad;
  logic searching, curHit, lastMiss, done, accept;

  assign hitPad = NPAD'(hitVec);

  always_comb begin
    searching = (stepQ != NO_BLK);
    curHit    = searching && hitPad[stepQ];
    lastMiss  = (stepQ == BLK_W'(NBLK - 1)) && !hitPad[stepQ];
    done      = curHit || lastMiss;
    inReady   = !searching || done;
    accept    = inValid && inReady;

    strb.load[0] = accept;
    for (int k = 1; k < NBLK; k++) begin
      strb.load[k] = (stepQ == BLK_W'(k - 1)) && !hitPad[stepQ];
    end
    strb.sel      = stepQ;
    strb.takeHit  = curHit;
    strb.takeMiss = lastMiss;

    if (accept)         stepD = '0;
    else if (done)      stepD = NO_BLK;
    else if (searching) stepD = stepQ + BLK_W'(1);
    else                stepD = stepQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stepQ <= NO_BLK;
    else       stepQ <= stepD;
  end
endmodule

// File: rtl/vlc_datapath.sv
module vlc_datapath
  import vlc_pkg::*;
(
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [CODE_W-1:0]           inCode,
  input  strobe_t                     strb,
  output logic [NBLK-1:0]             hitVec,
  output logic [NBLK-1:0][CODE_W-1:0] keys,
  output logic                        outValid,
  output logic [SYM_W-1:0]            outSym,
  output logic [LEN_W-1:0]            outLen,
  output logic [BLK_W-1:0]            outBlk,
  output logic                        outErr
);
  logic [NBLK-1:0][CODE_W-1:0] src;
  look_t lk [NPAD];

  always_comb begin
    src[0] = inCode;
    for (int k = 1; k < NBLK; k++) src[k] = keys[k-1];
    for (int k = 0; k < NBLK; k++) hitVec[k] = lk[k].hit;
  end

  // per-sub-table key registers: only the reached one loads
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      keys <= '0;
    end else begin
      for (int k = 0; k < NBLK; k++) begin
        if (strb.load[k]) keys[k] <= src[k];
      end
    end
  end

  generate
    for (genvar g = 0; g < NPAD; g++) begin : g_tab
      if (g < NBLK) begin : g_real
        vlc_subtable #(.BLK(g)) u_tab (.key(keys[g]), .res(lk[g]));
      end else begin : g_pad
        assign lk[g] = '0;
      end
    end
  endgenerate

  // output selection by matching index
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outSym   <= '0;
      outLen   <= '0;
      outBlk   <= '0;
      outErr   <= 1'b0;
    end else begin
      outValid <= strb.takeHit || strb.takeMiss;
      if (strb.takeHit) begin
        outSym <= lk[strb.sel].sym;
        outLen <= lk[strb.sel].len;
        outBlk <= strb.sel;
        outErr <= 1'b0;
      end else if (strb.takeMiss) begin
        outSym <= '0;
        outLen <= '0;
        outBlk <= NO_BLK;
        outErr <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/vlc_part_table.sv
module vlc_part_table
  import vlc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  output logic              inReady,
  input  logic [CODE_W-1:0] inCode,
  output logic              outValid,
  output logic [SYM_W-1:0]  outSym,
  output logic [LEN_W-1:0]  outLen,
  output logic [BLK_W-1:0]  outBlk,
  output logic              outErr
);
  strobe_t                     strb;
  logic [NBLK-1:0]             hitVec;
  logic [NBLK-1:0][CODE_W-1:0] keyBus;

  vlc_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .hitVec(hitVec),
    .inReady(inReady), .strb(strb)
  );

  vlc_datapath u_dp (
    .clk(clk), .rstN(rstN), .inCode(inCode), .strb(strb),
    .hitVec(hitVec), .keys(keyBus),
    .outValid(outValid), .outSym(outSym), .outLen(outLen),
    .outBlk(outBlk), .outErr(outErr)
  );
endmodule

// File: rtl/vlc_part_table_chk.sv
module vlc_part_table_chk
  import vlc_pkg::*;
(
  input logic                        clk,
  input logic                        rstN,
  input logic                        inReady,
  input logic                        outValid,
  input logic [LEN_W-1:0]            outLen,
  input logic [BLK_W-1:0]            outBlk,
  input logic                        outErr,
  input logic [NBLK-1:0]             load,
  input logic [NBLK-1:0][CODE_W-1:0] keys
);
  AST_MISS_FORM: assert property (@(posedge clk) disable iff (!rstN)
    outValid && outErr |-> outLen == '0 && outBlk == NO_BLK); // R5
  AST_HIT_FORM: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outErr |-> outLen != '0 && outBlk != NO_BLK); // R2
  AST_BLK0_TIMING: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outErr && outBlk == 2'd0 |-> $past(load[0], 2)); // R6
  AST_BLK1_TIMING: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outErr && outBlk == 2'd1 |-> $past(load[1], 2)); // R6
  AST_BLK2_TIMING: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outErr && outBlk == 2'd2 |-> $past(load[2], 2)); // R6
  AST_MISS_TIMING: assert property (@(posedge clk) disable iff (!rstN)
    outValid && outErr |-> $past(load[2], 2)); // R5
  AST_ONE_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(load)); // R8
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rstN)
    load[1] |-> !inReady); // R7
  AST_KEY0_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !load[0] |=> $stable(keys[0])); // R8
  AST_KEY1_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !load[1] |=> $stable(keys[1])); // R8
  AST_KEY2_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !load[2] |=> $stable(keys[2])); // R8
endmodule

bind vlc_part_table vlc_part_table_chk u_chk (
  .clk(clk), .rstN(rstN), .inReady(inReady), .outValid(outValid),
  .outLen(outLen), .outBlk(outBlk), .outErr(outErr),
  .load(strb.load), .keys(keyBus)
);

// File: tb/vlc_part_table_tb.sv
module vlc_part_table_tb;
  logic        clk = 1'b0;
  logic        rstN;
  logic        inValid;
  logic        inReady;
  logic [15:0] inCode;
  logic        outValid;
  logic [7:0]  outSym;
  logic [4:0]  outLen;
  logic [1:0]  outBlk;
  logic        outErr;

  int nChk = 0, nFail = 0, nAcc = 0, nOut = 0;
  bit running = 1'b1;

  always #5 clk = ~clk;

  vlc_part_table u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .inCode(inCode), .outValid(outValid), .outSym(outSym),
    .outLen(outLen), .outBlk(outBlk), .outErr(outErr)
  );

  always @(negedge clk) if (rstN && outValid) nOut++;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  endtask

  // codebook model built from symbol numbers
  function automatic int symLen(input int s);
    if (s == 0) return 2;
    if (s < 3) return 3;
    if (s < 15) return 6;
    if (s < 115) return 10;
    return 16;
  endfunction

  function automatic int symBlk(input int s);
    if (s < 3) return 0;
    if (s < 15) return 1;
    return 2;
  endfunction

  function automatic logic [15:0] place(input int pref, input int len, input logic [15:0] tail);
    logic [15:0] m;
    m = (len >= 16) ? 16'h0 : (16'hFFFF >> len);
    return (16'(pref) << (16 - len)) | (tail & m);
  endfunction

  function automatic logic [15:0] mkCode(input int s, input logic [15:0] tail);
    int p;
    if (s == 0) p = 3;
    else if (s == 1) p = 5;
    else if (s == 2) p = 4;
    else if (s < 15) p = s + 17;
    else if (s < 115) p = s - 15;
    else p = 16'h4000 + (s - 115);
    return place(p, symLen(s), tail);
  endfunction

  // kind 0: '00' + a (a >= 100); kind 1: '0100' + b (b >= 16)
  function automatic logic [15:0] mkErr(input int kind, input int v, input logic [15:0] tail);
    if (kind == 0) return place(v, 10, tail);
    return place(16'h4000 + v, 16, tail);
  endfunction

  task automatic runOne(input logic [15:0] code, input bit expErr, input int expSym,
                        input int expLen, input int expBlk, input string req);
    int lat, expLat;
    expLat = expErr ? 4 : expBlk + 2;
    @(negedge clk);
    check(inReady == 1'b1, "R7 idle ready", int'(inReady), 1);
    inValid = 1'b1;
    inCode  = code;
    nAcc++;
    @(negedge clk);
    inValid = 1'b0;
    inCode  = $urandom;
    lat = 1;
    while (!outValid && lat < 8) begin
      if (lat == 1 && expLat > 2)
        check(inReady == 1'b0, "R7 busy not ready", int'(inReady), 0);
      if (lat == expLat - 1)
        check(inReady == 1'b1, "R7 last step ready", int'(inReady), 1);
      @(negedge clk);
      lat++;
    end
    check(lat == expLat, "R6 R8 latency", lat, expLat);
    check(outErr == expErr, {req, " err"}, int'(outErr), int'(expErr));
    check(outSym == 8'(expSym), {req, " symbol"}, int'(outSym), expSym);
    check(outLen == 5'(expLen), {req, " length"}, int'(outLen), expLen);
    check(outBlk == 2'(expBlk), {req, " block"}, int'(outBlk), expBlk);
    @(negedge clk);
    check(outValid == 1'b0, "R9 single pulse", int'(outValid), 0);
  endtask

  task automatic runSym(input int s, input logic [15:0] tail);
    string req;
    case (symBlk(s))
      0: req = "R2";
      1: req = "R3";
      default: req = "R4";
    endcase
    runOne(mkCode(s, tail), 1'b0, s, symLen(s), symBlk(s), req);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (running) begin
      nFail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      summary();
    end
  end

  initial begin
    int sl [9] = '{0, 1, 2, 3, 14, 15, 114, 115, 130};
    logic [15:0] exp0 [8];
    void'($urandom(32'd20240611));
    rstN = 1'b0; inValid = 1'b0; inCode = 16'h0;
    repeat (3) @(negedge clk);
    check(outValid == 1'b0, "R1 reset valid", int'(outValid), 0);
    check(inReady == 1'b1, "R1 reset ready", int'(inReady), 1);
    rstN = 1'b1;

    // boundary symbols with all-zero and all-one tails (R6 tail bits)
    foreach (sl[i]) begin
      runSym(sl[i], 16'h0000);
      runSym(sl[i], 16'hFFFF);
    end

    // codes that miss every sub-table (R5)
    runOne(mkErr(0, 100, 16'h0000), 1'b1, 0, 0, 3, "R5");
    runOne(mkErr(0, 255, 16'hFFFF), 1'b1, 0, 0, 3, "R5");
    runOne(mkErr(1, 16, 16'h0000), 1'b1, 0, 0, 3, "R5");
    runOne(mkErr(1, 4095, 16'h0000), 1'b1, 0, 0, 3, "R5");
    runSym(0, 16'h1234);

    // back-to-back sub-table 0 codes: one per cycle (R7)
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (i >= 2) begin
        int s;
        s = int'(exp0[(i - 2) % 8]);
        check(outValid == 1'b1, "R7 stream valid", int'(outValid), 1);
        check(outSym == 8'(s) && outBlk == 2'd0, "R7 stream symbol", int'(outSym), s);
      end
      if (i < 8) begin
        int s;
        s = $urandom % 3;
        exp0[i] = 16'(s);
        check(inReady == 1'b1, "R7 stream ready", int'(inReady), 1);
        inValid = 1'b1;
        inCode  = mkCode(s, 16'($urandom));
        nAcc++;
      end else begin
        inValid = 1'b0;
      end
    end
    @(negedge clk);
    check(outValid == 1'b0, "R9 stream end", int'(outValid), 0);

    // random mix
    for (int n = 0; n < 400; n++) begin
      if ($urandom % 8 == 0) begin
        if ($urandom % 2 == 0)
          runOne(mkErr(0, 100 + ($urandom % 156), 16'($urandom)), 1'b1, 0, 0, 3, "R5");
        else
          runOne(mkErr(1, 16 + ($urandom % 4080), 16'($urandom)), 1'b1, 0, 0, 3, "R5");
      end else begin
        runSym($urandom % 131, 16'($urandom));
      end
    end

    repeat (3) @(negedge clk);
    check(nOut == nAcc, "R9 result count", nOut, nAcc);
    running = 1'b0;
    summary();
  end
endmodule